// File: doc/BRIEF.md
# Program Memory Table Read Unit

This unit executes the table-read instructions of a small microcontroller core. When the decoder strobes a start, the unit captures an 8-bit table pointer and builds an 11-bit program-memory address. The low eight address bits always come from the pointer. The upper page bits come from one of two sources, chosen by the instruction variant: the page of the current program counter, or the last page of program memory, where every page bit is 1.

The unit then reads one 16-bit word from a synchronous program memory. It sends the low byte to a data-memory destination over a one-cycle write-back port. In the same cycle, it loads the high byte into a table-high latch. Software can only read that latch. Each new table read overwrites it.

Each operation spans two machine cycles. In the first cycle `busy_o` is high and the read is issued. In the second cycle `done_o` is high, and the write-back and the latch update take place together. A new start may be accepted in that second cycle, so reads can run back to back.

Top module: `tblrd_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `wb_en_o` and `pm_rd_o` are low and `tblh_o` is zero.
- R2: When a start is accepted with `last_page_i` = 0, the next cycle has `pm_rd_o` = 1 and `pm_addr_o` = {`pc_page_i`, `tblp_i`}, both taken at the accepting edge.
- R3: When a start is accepted with `last_page_i` = 1, the next cycle has `pm_addr_o` = {3'b111, `tblp_i`}, whatever `pc_page_i` holds.
- R4: An accepted operation takes two cycles. In the first, `busy_o` = 1 and `done_o` = 0. In the second, `busy_o` = 0 and `done_o` = 1. After that, with no new start, both are low.
- R5: In the `done_o` cycle, `wb_en_o` = 1, `wb_addr_o` holds the destination sampled at start, and `wb_data_o` = `pm_data_i`[7:0]. Here `pm_data_i` is the word the memory returns one cycle after the read request. In all other cycles `wb_en_o` = 0.
- R6: At the clock edge that ends the `done_o` cycle, `tblh_o` loads `pm_data_i`[15:8]. It holds that value until the next done cycle ends, so a later read replaces the earlier high byte.
- R7: A start that arrives while `busy_o` = 1 is ignored. No extra operation follows, and `tblh_o` and the write-back reflect only the operation already running.
- R8: Pointer, page, variant and destination are sampled only at the accepting edge. Changing them during `busy_o` does not alter the address or the write-back destination.
- R9: A start that arrives in a `done_o` cycle is accepted, and `busy_o` is high in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe of a table read |
| last_page_i | input | 1 | Variant: 1 forces the last page, 0 uses the program counter page |
| pc_page_i | input | 3 | Page bits of the current program counter |
| tblp_i | input | 8 | Table pointer register value |
| dst_i | input | 7 | Data-memory destination address |
| pm_addr_o | output | 11 | Program-memory read address |
| pm_rd_o | output | 1 | Program-memory read request |
| pm_data_i | input | 16 | Program-memory word, valid one cycle after the request |
| wb_en_o | output | 1 | Low-byte write-back strobe |
| wb_addr_o | output | 7 | Write-back destination address |
| wb_data_o | output | 8 | Write-back data, the low byte of the word |
| tblh_o | output | 8 | Read-only table-high latch |
| busy_o | output | 1 | First cycle of an operation |
| done_o | output | 1 | Second cycle of an operation |

## Verification
The assertions check the following on every cycle:
- the busy-then-done order, and that a start arriving during busy never stretches an operation;
- that a write-back only follows a read request;
- the page forcing of the last-page variant and the address formed for the current-page variant;
- that the table-high latch changes only after a done cycle, and then to the high byte the memory returned.

Some behaviours only the bench scenarios can show. These are that the write-back carries the right byte to the right destination, that operands changed mid-operation have no effect, that a second read replaces the first high byte, and that back-to-back reads deliver both results.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } tr_state_e;
endpackage

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl
    import tblrd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic busy_o,
    output logic done_o
);
    typedef struct packed {
        tr_state_e st;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    // A start is taken in idle or in the finishing cycle, never mid-fetch
    always_comb begin
        ctl_d    = ctl_q;
        accept_o = start_i && (ctl_q.st != ST_FETCH);
        case (ctl_q.st)
            ST_IDLE:  if (accept_o) ctl_d.st = ST_FETCH;
            ST_FETCH: ctl_d.st = ST_DONE;
            ST_DONE:  ctl_d.st = accept_o ? ST_FETCH : ST_IDLE;
            default:  ctl_d.st = ST_IDLE;
        endcase
        busy_o = (ctl_q.st == ST_FETCH);
        done_o = (ctl_q.st == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE};
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/tblrd_addr_gen.sv
module tblrd_addr_gen #(
    parameter int PC_W  = 11,
    parameter int PTR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic                   last_page_i,
    input  logic [PC_W-PTR_W-1:0]  pc_page_i,
    input  logic [PTR_W-1:0]       tblp_i,
    output logic [PC_W-1:0]        addr_o
);
    localparam int PAGE_W = PC_W - PTR_W;

    typedef struct packed {
        logic [PC_W-1:0] addr;
    } addr_s;

    addr_s ag_d, ag_q;
    logic [PAGE_W-1:0] page_sel;

    // Each page bit is forced high for the last-page variant
    for (genvar i = 0; i < PAGE_W; i++) begin : g_page
        assign page_sel[i] = last_page_i ? 1'b1 : pc_page_i[i];
    end

    always_comb begin
        ag_d = ag_q;
        if (load_i) ag_d.addr = {page_sel, tblp_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ag_q <= '0;
        else        ag_q <= ag_d;
    end

    assign addr_o = ag_q.addr;
endmodule

// File: rtl/tblrd_hold.sv
module tblrd_hold #(
    parameter int WORD_W = 16,
    parameter int DATA_W = 8,
    parameter int DST_W  = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     done_i,
    input  logic [DST_W-1:0]         dst_i,
    input  logic [WORD_W-1:0]        pm_data_i,
    output logic                     wb_en_o,
    output logic [DST_W-1:0]         wb_addr_o,
    output logic [DATA_W-1:0]        wb_data_o,
    output logic [WORD_W-DATA_W-1:0] tblh_o
);
    localparam int HI_W = WORD_W - DATA_W;

    typedef struct packed {
        logic [DST_W-1:0] dst;
        logic [HI_W-1:0]  tblh;
    } hold_s;

    hold_s hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (done_i) hd_d.tblh = pm_data_i[WORD_W-1:DATA_W];
        if (load_i) hd_d.dst  = dst_i;
        wb_en_o   = done_i;
        wb_addr_o = hd_q.dst;
        wb_data_o = done_i ? pm_data_i[DATA_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    assign tblh_o = hd_q.tblh;
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit #(
    parameter int PC_W   = 11,
    parameter int PTR_W  = 8,
    parameter int WORD_W = 16,
    parameter int DATA_W = 8,
    parameter int DST_W  = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     last_page_i,
    input  logic [PC_W-PTR_W-1:0]    pc_page_i,
    input  logic [PTR_W-1:0]         tblp_i,
    input  logic [DST_W-1:0]         dst_i,
    output logic [PC_W-1:0]          pm_addr_o,
    output logic                     pm_rd_o,
    input  logic [WORD_W-1:0]        pm_data_i,
    output logic                     wb_en_o,
    output logic [DST_W-1:0]         wb_addr_o,
    output logic [DATA_W-1:0]        wb_data_o,
    output logic [WORD_W-DATA_W-1:0] tblh_o,
    output logic                     busy_o,
    output logic                     done_o
);
    logic accept;

    tblrd_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    tblrd_addr_gen #(.PC_W(PC_W), .PTR_W(PTR_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .last_page_i (last_page_i),
        .pc_page_i   (pc_page_i),
        .tblp_i      (tblp_i),
        .addr_o      (pm_addr_o)
    );

    tblrd_hold #(.WORD_W(WORD_W), .DATA_W(DATA_W), .DST_W(DST_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .done_i    (done_o),
        .dst_i     (dst_i),
        .pm_data_i (pm_data_i),
        .wb_en_o   (wb_en_o),
        .wb_addr_o (wb_addr_o),
        .wb_data_o (wb_data_o),
        .tblh_o    (tblh_o)
    );

    assign pm_rd_o = busy_o;
endmodule

// File: rtl/tblrd_checker.sv
module tblrd_checker #(
    parameter int PC_W  = 11,
    parameter int PTR_W = 8,
    parameter int HI_W  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   last_page_i,
    input logic [PC_W-PTR_W-1:0]  pc_page_i,
    input logic [PTR_W-1:0]       tblp_i,
    input logic [PC_W-1:0]        pm_addr_o,
    input logic                   pm_rd_o,
    input logic [HI_W-1:0]        hi_i,
    input logic                   wb_en_o,
    input logic [HI_W-1:0]        tblh_o,
    input logic                   busy_o,
    input logic                   done_o
);
    localparam int PAGE_W = PC_W - PTR_W;

    AST_BUSY_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n) busy_o |=> done_o && !busy_o); // R4
    AST_NO_STRETCH:     assert property (@(posedge clk) disable iff (!rst_n) busy_o |=> !busy_o); // R7
    AST_START_TAKEN:    assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> busy_o); // R9
    AST_WB_AFTER_RD:    assert property (@(posedge clk) disable iff (!rst_n) wb_en_o |-> $past(pm_rd_o)); // R5
    AST_LAST_PAGE:      assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o && last_page_i) |=> pm_addr_o[PC_W-1:PTR_W] == {PAGE_W{1'b1}}); // R3
    AST_CUR_PAGE:       assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o && !last_page_i) |=> pm_addr_o == {$past(pc_page_i), $past(tblp_i)}); // R2
    AST_TBLH_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !done_o |=> $stable(tblh_o)); // R6
    AST_TBLH_LOAD:      assert property (@(posedge clk) disable iff (!rst_n) done_o |=> tblh_o == $past(hi_i)); // R6
endmodule

bind tblrd_unit tblrd_checker #(.PC_W(PC_W), .PTR_W(PTR_W), .HI_W(WORD_W-DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .last_page_i (last_page_i),
    .pc_page_i   (pc_page_i),
    .tblp_i      (tblp_i),
    .pm_addr_o   (pm_addr_o),
    .pm_rd_o     (pm_rd_o),
    .hi_i        (pm_data_i[WORD_W-1:DATA_W]),
    .wb_en_o     (wb_en_o),
    .tblh_o      (tblh_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/tblrd_unit_bench.sv
module tblrd_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        last_page_i = 1'b0;
    logic [2:0]  pc_page_i = '0;
    logic [7:0]  tblp_i = '0;
    logic [6:0]  dst_i = '0;
    logic [10:0] pm_addr_o;
    logic        pm_rd_o;
    logic [15:0] pm_data_i = '0;
    logic        wb_en_o;
    logic [6:0]  wb_addr_o;
    logic [7:0]  wb_data_o;
    logic [7:0]  tblh_o;
    logic        busy_o;
    logic        done_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tblrd_unit u_tblrd_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_page_i(last_page_i),
        .pc_page_i(pc_page_i), .tblp_i(tblp_i), .dst_i(dst_i),
        .pm_addr_o(pm_addr_o), .pm_rd_o(pm_rd_o), .pm_data_i(pm_data_i),
        .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
        .tblh_o(tblh_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic [15:0] word_of(input logic [10:0] a);
        return {a[7:0] ^ 8'h96, a[7:0] + {5'd0, a[10:8]}};
    endfunction

    // Synchronous program memory model: word valid one cycle after request
    always @(posedge clk) if (pm_rd_o) pm_data_i <= word_of(pm_addr_o);

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic drive(input bit lp, input logic [2:0] pg, input logic [7:0] ptr, input logic [6:0] dst);
        start_i = 1'b1; last_page_i = lp; pc_page_i = pg; tblp_i = ptr; dst_i = dst;
    endtask

    // One complete read, checked cycle by cycle
    task automatic do_read(input bit lp, input logic [2:0] pg, input logic [7:0] ptr, input logic [6:0] dst);
        logic [10:0] ea;
        ea = lp ? {3'b111, ptr} : {pg, ptr};
        drive(lp, pg, ptr, dst);
        @(negedge clk);
        start_i = 1'b0;
        chk(lp ? "R3 address" : "R2 address", 32'(pm_addr_o), 32'(ea));
        chk("R2 read request", 32'(pm_rd_o), 1);
        chk("R4 busy first cycle", 32'({busy_o, done_o}), 32'b10);
        @(negedge clk);
        chk("R4 done second cycle", 32'({busy_o, done_o}), 32'b01);
        chk("R5 write-back", 32'({wb_en_o, wb_addr_o, wb_data_o}), 32'({1'b1, dst, word_of(ea)[7:0]}));
        @(negedge clk);
        chk("R6 table-high", 32'(tblh_o), 32'(word_of(ea)[15:8]));
        chk("R4 idle after", 32'({busy_o, done_o, wb_en_o}), 0);
    endtask

    task automatic t_reset;
        chk("R1 reset outputs", 32'({busy_o, done_o, wb_en_o, pm_rd_o}), 0);
        chk("R1 reset table-high", 32'(tblh_o), 0);
    endtask

    task automatic t_pages;
        do_read(1'b0, 3'b010, 8'h3C, 7'h21);
        do_read(1'b1, 3'b001, 8'hA5, 7'h05);
        do_read(1'b0, 3'b111, 8'h00, 7'h7F);
        do_read(1'b1, 3'b000, 8'hFF, 7'h00);
    endtask

    task automatic t_overwrite;
        logic [7:0] first;
        do_read(1'b0, 3'b011, 8'h12, 7'h10);
        first = tblh_o;
        repeat (3) @(negedge clk);
        chk("R6 table-high holds", 32'(tblh_o), 32'(first));
        do_read(1'b0, 3'b100, 8'h34, 7'h11);
        chk("R6 overwritten", 32'(tblh_o), 32'(word_of({3'b100, 8'h34})[15:8]));
    endtask

    task automatic t_ignore;
        logic [10:0] ea;
        ea = {3'b001, 8'h55};
        drive(1'b0, 3'b001, 8'h55, 7'h2A);
        @(negedge clk);
        drive(1'b1, 3'b110, 8'hEE, 7'h33);   // start during busy, new operands
        @(negedge clk);
        start_i = 1'b0;
        chk("R7 done of first only", 32'({busy_o, done_o}), 32'b01);
        chk("R8 destination kept", 32'(wb_addr_o), 32'h2A);
        chk("R8 data from first address", 32'(wb_data_o), 32'(word_of(ea)[7:0]));
        @(negedge clk);
        chk("R7 no extra operation", 32'({busy_o, done_o, pm_rd_o}), 0);
        chk("R7 table-high of first", 32'(tblh_o), 32'(word_of(ea)[15:8]));
    endtask

    task automatic t_sample;
        drive(1'b0, 3'b101, 8'h77, 7'h44);
        @(negedge clk);
        start_i = 1'b0; pc_page_i = 3'b010; tblp_i = 8'h99; last_page_i = 1'b1;
        #1;
        chk("R8 address kept", 32'(pm_addr_o), 32'({3'b101, 8'h77}));
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_b2b;
        logic [10:0] a1, a2;
        a1 = {3'b000, 8'h10};
        a2 = {3'b111, 8'h20};
        drive(1'b0, 3'b000, 8'h10, 7'h01);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        chk("R5 first write-back", 32'(wb_data_o), 32'(word_of(a1)[7:0]));
        drive(1'b1, 3'b000, 8'h20, 7'h02);   // start in done cycle
        @(negedge clk);
        start_i = 1'b0;
        chk("R9 busy right after", 32'({busy_o, done_o}), 32'b10);
        chk("R9 second address", 32'(pm_addr_o), 32'(a2));
        chk("R6 first table-high", 32'(tblh_o), 32'(word_of(a1)[15:8]));
        @(negedge clk);
        chk("R9 second write-back", 32'({wb_en_o, wb_addr_o, wb_data_o}), 32'({1'b1, 7'h02, word_of(a2)[7:0]}));
        @(negedge clk);
        chk("R9 second table-high", 32'(tblh_o), 32'(word_of(a2)[15:8]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pages();
        t_overwrite();
        t_ignore();
        t_sample();
        t_b2b();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule